// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns one system clock into the bit-rate timing pulse of a serial port. It runs two stages in series. An integer prescaler divides the clock by `scale + 1`. A phase accumulator, one bit wider than the step field, then adds `step` on every prescaler strobe. Every carry out of the top bit of the accumulator becomes one output tick. The average tick rate is therefore `f_clk / (scale + 1) * step / 2^(STEP_W+1)`. With the default widths (8-bit scale, 16-bit step, 17-bit accumulator) the rate is `f_clk / (scale+1) * step / 131072`.

The host works out `scale` and `step` for the wanted bit rate. It loads both values at once as a single packed word with a one-cycle write strobe. A write restarts both stages from zero, so the first tick at the new rate has no leftover phase from the old setting. For the usual serial range of 300 to 3,000,000 bit/s, the slowest setting is `scale` at its maximum with `step = 1`, and the fastest is `scale = 0` with `step` at its maximum. The `tick` output is a plain one-cycle strobe. It has no back-pressure, and the port logic that consumes it is always ready.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset `tick` is low, and it stays low until a configuration word with a nonzero step is written (the reset configuration is scale 0, step 0).
- R2: The configuration word holds `step` in bits [STEP_W-1:0] and `scale` in bits [SCALE_W+STEP_W-1:STEP_W]. A write takes effect on the clock edge at which `cfg_we` is high.
- R3: `tick` is high for at most one cycle per prescaler period. Counting enabled cycles e = 0, 1, 2, ... after a write, it can be high only in a cycle where (e+1) is a multiple of (scale+1).
- R4: At the p-th prescaler strobe after a write (p = 1, 2, ...), `tick` is high exactly when floor(p*step / 2^(STEP_W+1)) exceeds floor((p-1)*step / 2^(STEP_W+1)).
- R5: Writing a configuration clears the prescaler and the accumulator, even in the middle of a run. `tick` is low in the cycle of the write.
- R6: With `step` equal to zero, `tick` never goes high.
- R7: While `en` is low, `tick` is low and both stages hold their state. When `en` returns high, counting resumes from the held state.
- R8: With the default widths, scale 0 and step 65535 give 499 ticks in 1000 enabled cycles, and scale 1 with step 32768 gives a tick every 8 cycles.
- R9: A configuration write takes effect whatever the level of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable; when low, all state is held |
| cfg_we | input | 1 | One-cycle strobe that loads `cfg_word` and restarts both stages |
| cfg_word | input | SCALE_W+STEP_W | Packed configuration: scale in the upper bits, step in the low STEP_W bits |
| tick | output | 1 | One-cycle bit-rate strobe |

## Verification
A prescaler counter that drifts or fails to clear moves every tick off the (scale+1) grid. This shows on the first tick after a write, within scale+1 cycles. A corrupted accumulator phase adds or drops a tick, or shifts one by a whole prescaler period. That error is visible no later than the next carry, within 2^(STEP_W+1)/step strobes. Because the bench compares every cycle against the closed-form floor formula, a single misplaced tick is caught in the cycle it occurs. A hold fault with `en` low shows as the whole tick train shifting once counting resumes.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned DEF_SCALE_W = 8;
  localparam int unsigned DEF_STEP_W  = 16;

  function automatic int unsigned acc_width(input int unsigned step_w);
    return step_w + 1;
  endfunction
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg #(
  parameter int unsigned SCALE_W = 8,
  parameter int unsigned STEP_W  = 16,
  localparam int unsigned CFG_W  = SCALE_W + STEP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CFG_W-1:0]   word_in,
  output logic [SCALE_W-1:0] scale_q,
  output logic [STEP_W-1:0]  step_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      step_q  <= '0;
    end else if (load) begin
      scale_q <= word_in[CFG_W-1:STEP_W];
      step_q  <= word_in[STEP_W-1:0];
    end
  end
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int unsigned SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic [SCALE_W-1:0] limit,
  output logic [SCALE_W-1:0] cnt_o,
  output logic               strobe
);
  logic [SCALE_W-1:0] cnt_q;
  logic               wrap;

  assign wrap   = (cnt_q == limit);
  assign strobe = en && !clr && wrap;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int unsigned STEP_W = 16,
  localparam int unsigned ACC_W = fbg_pkg::acc_width(STEP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clr,
  input  logic [STEP_W-1:0] step,
  output logic [ACC_W-1:0]  acc_o,
  output logic              carry
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {2'b00, step};
  assign carry = adv && sum[ACC_W];
  assign acc_o = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
    end else if (adv) begin
      acc_q <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned SCALE_W = fbg_pkg::DEF_SCALE_W,
  parameter int unsigned STEP_W  = fbg_pkg::DEF_STEP_W,
  localparam int unsigned CFG_W  = SCALE_W + STEP_W,
  localparam int unsigned ACC_W  = fbg_pkg::acc_width(STEP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             tick
);
  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  step_q;
  logic [SCALE_W-1:0] pre_cnt;
  logic [ACC_W-1:0]   acc_q;
  logic               pre_strobe;

  fbg_cfg_reg #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .word_in(cfg_word),
    .scale_q(scale_q), .step_q(step_q)
  );

  fbg_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(cfg_we), .limit(scale_q),
    .cnt_o(pre_cnt), .strobe(pre_strobe)
  );

  fbg_phase_acc #(.STEP_W(STEP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(pre_strobe), .clr(cfg_we), .step(step_q),
    .acc_o(acc_q), .carry(tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned SCALE_W = 8,
  parameter int unsigned STEP_W  = 16,
  localparam int unsigned ACC_W  = STEP_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               cfg_we,
  input logic               tick,
  input logic [SCALE_W-1:0] cnt,
  input logic [SCALE_W-1:0] scale_q,
  input logic [STEP_W-1:0]  step_q,
  input logic [ACC_W-1:0]   acc
);
  // R7
  en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_we) |=> ($stable(cnt) && $stable(acc)));
  // R5
  clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt == '0 && acc == '0));
  // R5
  no_tick_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !tick);
  // R3
  tick_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt == scale_q));
  // R3
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && scale_q != '0) |=> !tick);
  // R6
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == '0) |-> !tick);
endmodule

bind frac_baud_gen fbg_checker #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .tick(tick),
  .cnt(pre_cnt), .scale_q(scale_q), .step_q(step_q), .acc(acc_q)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  localparam int SW_S = 3;
  localparam int ST_S = 4;
  localparam longint MOD_S = 64'd1 << (ST_S + 1);
  localparam longint MOD_B = 64'd1 << 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_b = 1'b0, we_b = 1'b0;
  logic [23:0] cfg_b = '0;
  logic tick_b;
  logic en_s = 1'b0, we_s = 1'b0;
  logic [SW_S+ST_S-1:0] cfg_s = '0;
  logic tick_s;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en_b), .cfg_we(we_b), .cfg_word(cfg_b), .tick(tick_b)
  );

  frac_baud_gen #(.SCALE_W(SW_S), .STEP_W(ST_S)) u_small (
    .clk(clk), .rst_n(rst_n), .en(en_s), .cfg_we(we_s), .cfg_word(cfg_s), .tick(tick_s)
  );

  task automatic check(input string req, input logic act, input logic exp, input int info);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tick=%0b expected %0b (ctx %0d)", req, act, exp, info);
    end
  endtask

  function automatic logic model_tick(input longint e, input longint s, input longint st,
                                      input longint m);
    longint p;
    if (((e + 1) % (s + 1)) != 0) return 1'b0;
    p = (e + 1) / (s + 1);
    return ((p * st) / m) != (((p - 1) * st) / m);
  endfunction

  // Write a configuration to the small instance, then run for n cycles.
  // mode 0: en always high; mode 1: en toggles by a pattern; mode 2: write with en low
  task automatic run_small(input int s, input int st, input int n, input int mode);
    longint e = 0;
    @(negedge clk);
    cfg_s = {s[SW_S-1:0], st[ST_S-1:0]};
    we_s = 1'b1;
    en_s = (mode == 2) ? 1'b0 : 1'b1;
    #1;
    check("R5", tick_s, 1'b0, s * 100 + st);
    @(negedge clk);
    we_s = 1'b0;
    for (int c = 0; c < n; c++) begin
      en_s = (mode == 1) ? (((c % 5) != 1) && ((c % 7) != 3)) : 1'b1;
      #1;
      if (!en_s) check("R7", tick_s, 1'b0, c);
      else if (st == 0) check("R6", tick_s, 1'b0, c);
      else check((mode == 2) ? "R9" : "R4", tick_s,
                 model_tick(e, s, st, MOD_S), s * 100 + st);
      if (en_s) e++;
      @(negedge clk);
    end
  endtask

  task automatic count_big(input int s, input int st, input int n, output int cnt,
                           output int first_gap_bad);
    int last = -1;
    cnt = 0;
    first_gap_bad = 0;
    @(negedge clk);
    cfg_b = {s[7:0], st[15:0]};
    we_b = 1'b1;
    en_b = 1'b1;
    @(negedge clk);
    we_b = 1'b0;
    for (int c = 0; c < n; c++) begin
      #1;
      if (tick_b) begin
        if (model_tick(c, s, st, MOD_B) !== 1'b1) first_gap_bad++;
        cnt++;
        last = c;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int cnt, bad;
    repeat (3) @(negedge clk);
    // R1: quiet through and after reset
    for (int c = 0; c < 4; c++) begin
      check("R1", tick_s, 1'b0, c);
      check("R1", tick_b, 1'b0, c);
      @(negedge clk);
    end
    rst_n = 1'b1;
    en_s = 1'b1;
    en_b = 1'b1;
    for (int c = 0; c < 20; c++) begin
      #1;
      check("R1", tick_s, 1'b0, c);
      check("R1", tick_b, 1'b0, c);
      @(negedge clk);
    end
    // R2 R3 R4 R6: exhaustive sweep of the small configuration, back to back (R5)
    for (int s = 0; s < (1 << SW_S); s++)
      for (int st = 0; st < (1 << ST_S); st++)
        run_small(s, st, (s + 1) * 24, 0);
    // R7: enable gaps
    run_small(2, 13, 200, 1);
    run_small(0, 31 & 15, 120, 1);
    run_small(5, 7, 300, 1);
    // R9: write while en low
    run_small(3, 9, 100, 2);
    // R5: rewrite mid-run, after partial phase
    run_small(1, 11, 7, 0);
    run_small(4, 3, 150, 0);
    // R8: default-width extremes
    count_big(0, 65535, 1000, cnt, bad);
    n_chk++;
    if (cnt != 499 || bad != 0) begin
      n_fail++;
      $display("FAIL R8: ticks=%0d misplaced=%0d expected 499 and 0", cnt, bad);
    end
    count_big(1, 32768, 800, cnt, bad);
    n_chk++;
    if (cnt != 100 || bad != 0) begin
      n_fail++;
      $display("FAIL R8: ticks=%0d misplaced=%0d expected 100 and 0", cnt, bad);
    end
    // R6 at default width
    count_big(255, 0, 600, cnt, bad);
    n_chk++;
    if (cnt != 0) begin
      n_fail++;
      $display("FAIL R6: ticks=%0d expected 0", cnt);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule